// File: doc/BRIEF.md
# Unaligned Word Access Sequencer

This block turns byte and word requests at any 20-bit byte address into cycles on a 16-bit data bus. The bus has two byte banks. The even bank sits on the low lane, bits 7:0, and is selected when address bit 0 is low. The odd bank sits on the high lane, bits 15:8, and is selected by a high-lane select output. A request that fits in one aligned halfword costs one bus cycle. A word that starts at an odd address is split into two cycles: the first reaches the odd bank, the second reaches the even bank at the following address. The block routes each byte to the right lane for writes and rebuilds the word for reads.

Requests enter through a simple valid/ready pair and are accepted only while the block is idle. Each bus cycle takes exactly one clock. The memory returns read data in the same clock as the cycle and stores write data at the clock edge that ends the cycle. A single-clock `done` pulse marks the end of each request. With it come the read result and the number of bus cycles the request used, so the cost of misalignment can be seen at the ports.

Top module: `unaligned_access_seq`

## Requirements
- R1: A word request at an even address uses exactly one bus cycle at that address, with address bit 0 low and `bus_hi_sel` high. Both lanes carry the word: low byte on bits 7:0, high byte on bits 15:8.
- R2: A word request at an odd address uses exactly two consecutive bus cycles. The first is at the request address with `bus_hi_sel` high, and carries the word's low byte on bits 15:8.
- R3: The second cycle of a split word has address bit 0 low and `bus_hi_sel` low. It carries the word's high byte on bits 7:0. On reads, `rd_data` is {second-cycle bits 7:0, first-cycle bits 15:8}.
- R4: Writes are split and lane-steered by the same rules as reads. A later read of the written bytes returns the written value.
- R5: The second cycle of a split word uses the request address plus one, modulo 2^20, so 0xFFFFF is followed by 0x00000.
- R6: A byte request uses one bus cycle. At an even address it uses the low lane, with address bit 0 low and `bus_hi_sel` low. At an odd address it uses the high lane, with address bit 0 high and `bus_hi_sel` high. A byte read returns the byte in `rd_data[7:0]` with `rd_data[15:8]` = 0. A byte write takes the byte from `req_wdata[7:0]`.
- R7: In every bus cycle at least one lane is selected, and a write changes only the bank bytes of the selected lanes.
- R8: `done` is high for exactly one clock, the clock right after the last bus cycle of a request.
- R9: `req_ready` is high only while idle. A request presented while busy is ignored and changes no memory byte.
- R10: With `done`, `cyc_count` reports the number of bus cycles the request used: 1 or 2.
- R11: After reset `req_ready` is 1, and `done` and `bus_cyc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a valid request is taken at this edge |
| req_is_word | input | 1 | 1 = word request, 0 = byte request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address of the request (word: its low byte) |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| cyc_count | output | 2 | Bus cycles used, valid with `done` |
| bus_cyc | output | 1 | A bus cycle is in progress this clock |
| bus_we | output | 1 | The current bus cycle is a write |
| bus_addr | output | 20 | Bus byte address; bit 0 low selects the low lane |
| bus_hi_sel | output | 1 | High-lane (odd bank) select |
| bus_wdata | output | 16 | Write data by lane; unselected lanes are zero |
| bus_rdata | input | 16 | Read data by lane, same clock as the cycle |

## Verification
The bench builds the block with its default parameters: a 20-bit address and 8-bit lanes. At that width the top address 0xFFFFF can be reached, so the wrap of a split word into address 0 is exercised. The same full-width address is also used to check that bytes near the top and bottom of memory are stored in the correct bank. Because lanes are eight bits wide, each byte written into one bank can be read back beside an untouched neighbour in the other bank.

// File: rtl/useq_pkg.sv
// Shared types for the unaligned access sequencer.
// Assumes a two-lane bus whose lane 0 is the even byte bank.
package useq_pkg;

    // Sequencer phase: idle, first bus cycle, second bus cycle, completion.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    // Per-request access plan derived from address and size.
    typedef struct packed {
        logic split;     // word at odd address: two bus cycles
        logic first_hi;  // high lane is selected in the first cycle
    } lane_plan_t;

endpackage

// File: rtl/useq_plan.sv
// Access planner: decides from the latched address and size whether a
// request needs one or two bus cycles, and which lanes the first cycle uses.
// Purely combinational; assumes addr bit 0 picks the bank.
module useq_plan
    import useq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_word,
    output lane_plan_t        plan
);

    // Derive split decision and first-cycle high-lane use.
    always_comb begin
        plan.split    = is_word && addr[0];
        plan.first_hi = is_word || addr[0];
    end

endmodule

// File: rtl/useq_ctrl.sv
// Sequencer control: accepts a request only when idle, latches it, and
// steps through one or two bus cycles followed by a one-clock completion.
// Also records how many bus cycles the request consumed.
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_word,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              split,
    output seq_state_e        state,
    output logic [ADDR_W-1:0] addr_q,
    output logic              word_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [1:0]        cyc_count
);

    // Phase register, request capture and cycle tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            word_q    <= 1'b0;
            write_q   <= 1'b0;
            wdata_q   <= '0;
            cyc_count <= 2'd0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q    <= req_addr;
                        word_q    <= req_is_word;
                        write_q   <= req_write;
                        wdata_q   <= req_wdata;
                        cyc_count <= 2'd0;
                        state     <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    cyc_count <= 2'd1;
                    state     <= split ? ST_SECOND : ST_DONE;
                end
                ST_SECOND: begin
                    cyc_count <= 2'd2;
                    state     <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request fields must not move while a request is in flight (R9).
    assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(addr_q) && $stable(wdata_q) && $stable(write_q));

    // A split request always runs a second cycle right after the first (R2).
    assert_split_runs_twice_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && split) |=> (state == ST_SECOND));

endmodule

// File: rtl/useq_lanes.sv
// Lane driver: forms the bus address, high-lane select and per-lane write
// data for the current phase. Lane 0 is the even bank, lane 1 the odd bank.
// The second cycle of a split word uses the next byte address.
module useq_lanes
    import useq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  seq_state_e          state,
    input  logic [ADDR_W-1:0]   addr_q,
    input  logic [2*LANE_W-1:0] wdata_q,
    input  lane_plan_t          plan,
    output logic                bus_cyc,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_hi_sel,
    output logic [2*LANE_W-1:0] bus_wdata
);

    localparam int NUM_LANES = 2;

    logic in_first;
    logic in_second;

    // Phase decode, address selection and high-lane select.
    always_comb begin
        in_first   = (state == ST_FIRST);
        in_second  = (state == ST_SECOND);
        bus_cyc    = in_first || in_second;
        bus_addr   = in_second ? (addr_q + ADDR_W'(1)) : addr_q;
        bus_hi_sel = in_first && plan.first_hi;
    end

    // Per-lane write data: each lane picks a request byte or stays zero.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic en;
        logic take_hi;
        if (g == 0) begin : g_even
            assign en      = bus_cyc && !bus_addr[0];
            assign take_hi = in_second;
        end else begin : g_odd
            assign en      = bus_hi_sel;
            assign take_hi = in_first && plan.first_hi && !addr_q[0];
        end
        assign bus_wdata[g*LANE_W +: LANE_W] =
            !en     ? '0 :
            take_hi ? wdata_q[2*LANE_W-1:LANE_W] : wdata_q[LANE_W-1:0];
    end

    // Every bus cycle selects at least one lane (R7).
    assert_lane_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_hi_sel || !bus_addr[0]));

    // Unselected lanes carry no data (R7).
    assert_idle_lane_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_addr[0]) |-> (bus_wdata[LANE_W-1:0] == '0));

endmodule

// File: rtl/useq_gather.sv
// Read gatherer: captures bus read data at the end of each bus cycle and
// builds the request result. Bytes are zero-extended; a split word takes
// its low byte from the high lane of cycle one and its high byte from the
// low lane of cycle two. Writes leave the result untouched.
module useq_gather
    import useq_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  seq_state_e          state,
    input  logic                write_q,
    input  logic                addr0,
    input  lane_plan_t          plan,
    input  logic [2*LANE_W-1:0] bus_rdata,
    output logic [2*LANE_W-1:0] rd_data
);

    logic [LANE_W-1:0] lo_lane;
    logic [LANE_W-1:0] hi_lane;
    logic              both_lanes;

    // Split incoming read data into lanes.
    always_comb begin
        lo_lane    = bus_rdata[LANE_W-1:0];
        hi_lane    = bus_rdata[2*LANE_W-1:LANE_W];
        both_lanes = plan.first_hi && !addr0;
    end

    // Result register updated per read bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (!write_q) begin
            if (state == ST_FIRST) begin
                if (both_lanes) rd_data <= bus_rdata;
                else            rd_data <= {{LANE_W{1'b0}}, (addr0 ? hi_lane : lo_lane)};
            end else if (state == ST_SECOND) begin
                rd_data[2*LANE_W-1:LANE_W] <= lo_lane;
            end
        end
    end

    // The second cycle fills only the upper result byte (R3).
    assert_second_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND) |=> $stable(rd_data[LANE_W-1:0]));

endmodule

// File: rtl/unaligned_access_seq.sv
// Top of the unaligned access sequencer. Accepts one byte or word request
// at a time and runs it as one or two bus cycles on a two-bank bus.
// Assumes the memory answers reads in the same clock and writes at the
// clock edge that ends the cycle.
module unaligned_access_seq
    import useq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_is_word,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    output logic                done,
    output logic [2*LANE_W-1:0] rd_data,
    output logic [1:0]          cyc_count,
    output logic                bus_cyc,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_hi_sel,
    output logic [2*LANE_W-1:0] bus_wdata,
    input  logic [2*LANE_W-1:0] bus_rdata
);

    localparam int DATA_W = 2 * LANE_W;

    seq_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic              word_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    lane_plan_t        plan;

    useq_plan #(.ADDR_W(ADDR_W)) u_plan (
        .addr    (addr_q),
        .is_word (word_q),
        .plan    (plan)
    );

    useq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_word (req_is_word),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .split       (plan.split),
        .state       (state),
        .addr_q      (addr_q),
        .word_q      (word_q),
        .write_q     (write_q),
        .wdata_q     (wdata_q),
        .cyc_count   (cyc_count)
    );

    useq_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .plan       (plan),
        .bus_cyc    (bus_cyc),
        .bus_addr   (bus_addr),
        .bus_hi_sel (bus_hi_sel),
        .bus_wdata  (bus_wdata)
    );

    useq_gather #(.LANE_W(LANE_W)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .write_q   (write_q),
        .addr0     (addr_q[0]),
        .plan      (plan),
        .bus_rdata (bus_rdata),
        .rd_data   (rd_data)
    );

    // Handshake and write strobe decode.
    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_DONE);
        bus_we    = bus_cyc && write_q;
    end

    // Completion is a single-clock pulse (R8).
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Completion follows directly on the last bus cycle (R8).
    assert_done_after_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_cyc) && !bus_cyc));

    // No request is taken while a bus cycle runs (R9).
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !req_ready);

    // Reported cycle count is one or two (R10).
    assert_count_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_count == 2'd1 || cyc_count == 2'd2));

    // The follow-on cycle uses the next byte address, wrapping (R5).
    assert_next_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |-> (bus_addr == ADDR_W'($past(bus_addr) + 1'b1)));

    // The follow-on cycle uses only the low lane (R3).
    assert_second_low_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |-> (!bus_hi_sel && !bus_addr[0]));

    // No request runs more than two bus cycles (R2).
    assert_no_third_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |=> !bus_cyc);

endmodule

// File: tb/unaligned_access_seq_tb.sv
module unaligned_access_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_word = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic [1:0]  cyc_count;
    logic        bus_cyc;
    logic        bus_we;
    logic [19:0] bus_addr;
    logic        bus_hi_sel;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unaligned_access_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_word(req_is_word), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .cyc_count(cyc_count),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_hi_sel(bus_hi_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Initial memory contents, a function of address.
    function automatic logic [7:0] seed(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    // Bank memory behind the bus, and an independent flat reference.
    logic [7:0] bank_mem [int];
    logic [7:0] ref_mem  [int];

    function automatic logic [7:0] bank_rd(input logic [19:0] a);
        return bank_mem.exists(int'(a)) ? bank_mem[int'(a)] : seed(a);
    endfunction
    function automatic logic [7:0] ref_rd(input logic [19:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : seed(a);
    endfunction

    // Bus memory model: answers reads and stores selected lanes.
    always @(negedge clk) begin
        bus_rdata <= {bank_rd({bus_addr[19:1], 1'b1}), bank_rd({bus_addr[19:1], 1'b0})};
        if (bus_cyc && bus_we) begin
            if (!bus_addr[0]) bank_mem[int'({bus_addr[19:1], 1'b0})] = bus_wdata[7:0];
            if (bus_hi_sel)   bank_mem[int'({bus_addr[19:1], 1'b1})] = bus_wdata[15:8];
        end
    end

    typedef struct {
        bit          rd;
        logic [15:0] data;
        int          ncyc;
        bit          hi;
        bit          a0;
        string       rq;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Driver: issue one request and push its expected outcome.
    task automatic issue(input bit word, input bit wr, input logic [19:0] a,
                         input logic [15:0] d, input string rq);
        exp_t e;
        logic [19:0] a1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        a1 = a + 20'd1;
        e.rd   = !wr;
        e.ncyc = (word && a[0]) ? 2 : 1;
        e.hi   = word || a[0];
        e.a0   = a[0];
        e.rq   = rq;
        if (wr) begin
            ref_mem[int'(a)] = d[7:0];
            if (word) ref_mem[int'(a1)] = d[15:8];
            e.data = '0;
        end else begin
            e.data = word ? {ref_rd(a1), ref_rd(a)} : {8'h00, ref_rd(a)};
        end
        sb.push_back(e);
        req_is_word = word; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: counts bus cycles, pops the scoreboard on completion.
    int  ncyc_seen = 0;
    bit  hi_first, a0_first;
    bit  prev_cyc = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cyc) begin
                ncyc_seen++;
                if (ncyc_seen == 1) begin hi_first = bus_hi_sel; a0_first = bus_addr[0]; end
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk("R9", "unexpected completion", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.rq, "bus cycles seen", ncyc_seen, e.ncyc);
                    chk("R10", "cyc_count", {30'd0, cyc_count}, e.ncyc);
                    chk(e.rq, "first high-lane select", {31'd0, hi_first}, {31'd0, e.hi});
                    chk(e.rq, "first address bit 0", {31'd0, a0_first}, {31'd0, e.a0});
                    chk("R8", "bus busy in clock before done", {31'd0, prev_cyc}, 32'd1);
                    if (e.rd) chk(e.rq, "rd_data", {16'd0, rd_data}, {16'd0, e.data});
                end
                ncyc_seen = 0;
            end
            prev_cyc = bus_cyc;
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "req_ready", {31'd0, req_ready}, 32'd1);
        chk("R11", "done", {31'd0, done}, 32'd0);
        chk("R11", "bus_cyc", {31'd0, bus_cyc}, 32'd0);

        // R1 aligned words, R6 bytes
        issue(1, 1, 20'h00100, 16'hBEEF, "R1 R4");
        issue(1, 0, 20'h00100, 16'h0000, "R1");
        issue(0, 0, 20'h00100, 16'h0000, "R6");
        issue(0, 0, 20'h00101, 16'h0000, "R6");
        issue(1, 0, 20'h00346, 16'h0000, "R1");

        // R2 R3 odd words, read and write
        issue(1, 0, 20'h00203, 16'h0000, "R2 R3");
        issue(1, 1, 20'h00203, 16'h1234, "R2 R4");
        issue(1, 0, 20'h00203, 16'h0000, "R3 R4");
        issue(0, 0, 20'h00203, 16'h0000, "R4 R6");
        issue(0, 0, 20'h00204, 16'h0000, "R4 R6");
        issue(1, 0, 20'h00202, 16'h0000, "R7");

        // R7 byte writes leave the neighbour bank untouched
        issue(0, 1, 20'h00301, 16'hFFA5, "R6 R7");
        issue(1, 0, 20'h00300, 16'h0000, "R7");
        issue(0, 1, 20'h00400, 16'hEE3C, "R6 R7");
        issue(1, 0, 20'h00400, 16'h0000, "R7");

        // R5 wrap from the top address
        issue(1, 1, 20'hFFFFF, 16'hCAFE, "R5 R4");
        issue(0, 0, 20'hFFFFF, 16'h0000, "R5");
        issue(0, 0, 20'h00000, 16'h0000, "R5");
        issue(1, 0, 20'hFFFFF, 16'h0000, "R5");

        // R9 request while busy is ignored
        issue(1, 0, 20'h00501, 16'h0000, "R2");
        req_is_word = 1'b0; req_write = 1'b1; req_addr = 20'h00600; req_wdata = 16'h0077;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        issue(1, 0, 20'h00600, 16'h0000, "R9");

        // Mixed patterns across alignments
        for (int i = 0; i < 8; i++) begin
            logic [19:0] a;
            a = 20'h0A000 + 20'(i * 37);
            issue(1, 1, a, 16'(16'h1111 * (i + 1)), "R4");
            issue(1, 0, a, 16'h0000, (a[0] ? "R2" : "R1"));
            issue(0, 0, a + 20'd1, 16'h0000, "R6");
        end

        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule